// File: doc/BRIEF.md
# Serial DAC Frame Receiver

This block is the digital front end of a serial-input voltage DAC. A fast system clock oversamples a three-wire link made of an active-low frame select, a serial clock and a data line. The block shifts in one framed command word, MSB first, with each bit taken on a falling edge of the serial clock. When the last bit of the frame arrives it executes the command. The command either loads a new DAC code or changes the output-stage mode, and it raises a one-cycle update strobe.

A frame whose select line rises early is discarded and leaves no trace. A frame whose leading bits mark it as a software reset cannot be cancelled: once those bits are in, it executes even when the select line rises early. The code register starts at zero scale or midscale, as a parameter chooses, and keeps that value until a command executes.

With the default `CODE_W = 16` a frame is 24 bits long. Bits 23..18 are zero in a normal command, bits 17..16 carry the mode and bits 15..0 carry the code. With `CODE_W = 14` a frame is 16 bits, with the mode in bits 15..14 and the code in bits 13..0.

Top module: `dacrx_top`

## Requirements
- R1: Reset gives `dacCode` = midscale (0x8000 at the defaults, `RESET_MID = 1`; zero when `RESET_MID = 0`), `outMode` = 00 and `update` = 0.
- R2: A frame starts on a falling edge of `frameSyncN`. Each bit is sampled on a falling edge of `serClk`, MSB first. The command executes on the 24th falling edge and `update` is high for exactly one system clock cycle per executed command.
- R3: A frame with bit 23 = 0 and mode bits 17..16 = 00 loads bits 15..0 into `dacCode` and sets `outMode` to 00.
- R4: `outMode` follows the mode bits 17..16 of the last executed command: 01 is three-state, 10 is a 100 kΩ load to ground and 11 is a 1 kΩ load to ground.
- R5: A command with nonzero mode bits changes only `outMode`. `dacCode` keeps its stored value and the code field of that frame is ignored.
- R6: If `frameSyncN` rises before the 24th falling clock edge and the frame is not a software reset, the frame is discarded. `dacCode`, `outMode` and `update` stay unchanged.
- R7: A frame with bit 23 = 1 is a software reset. It returns `dacCode` to the R1 value and `outMode` to 00, and raises `update`.
- R8: A software reset cannot be aborted. Once bit 23 has been received as 1, an early rise of `frameSyncN` still executes the reset, with `update` raised.
- R9: Falling edges of `serClk` after the 24th edge, with `frameSyncN` still low, have no effect. The next frame needs `frameSyncN` to go high and then fall again.
- R10: Falling edges of `serClk` while `frameSyncN` is high have no effect, and they do not corrupt the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all pins are oversampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| frameSyncN | input | 1 | Active-low frame select |
| serClk | input | 1 | Serial clock; bits are taken on its falling edge |
| serDin | input | 1 | Serial data, MSB first |
| dacCode | output | CODE_W | Held DAC code |
| outMode | output | 2 | Output-stage mode (00 normal, 01 three-state, 10 100 kΩ, 11 1 kΩ) |
| update | output | 1 | One-cycle strobe when a command executes |

## Verification
The hardest case to reach from the pins is an aborted frame that must still act: a software reset cut short after only a few bits. Reaching it means driving a partial frame with bit 23 set and then raising the select line mid-word. The bench does this at several cut points and compares the result with discarded partial frames whose first bit is zero. The bench also sends surplus clock edges after a complete word and clock edges outside any frame, and it checks that the strobe scoreboard sees no unexpected update.

// File: rtl/dacrx_pkg.sv
package dacrx_pkg;

  typedef enum logic [1:0] {
    MODE_DRIVE  = 2'b00,
    MODE_FLOAT  = 2'b01,
    MODE_WEAK   = 2'b10,
    MODE_STRONG = 2'b11
  } outStage_e;

  typedef struct packed {
    logic clear;     // start or abandon a frame
    logic shift;     // take one serial bit
    logic prefix;    // the bit belongs to the reset-marker prefix
    logic exec;      // last bit: execute the command
    logic forceRst;  // early end of a committed software reset
  } frameStrobes_t;

endpackage

// File: rtl/dacrx_in_sync.sv
module dacrx_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic frameSyncN,
  input  logic serClk,
  input  logic serDin,
  output logic frameFall,
  output logic frameRise,
  output logic sclkFall,
  output logic dinSmp
);
  localparam logic [2:0] IDLE_VAL = 3'b001;  // {din, sclk, syncN}

  logic [2:0] pins;
  logic [2:0] stage [STAGES];
  logic [1:0] prevLvl;

  assign pins = {serDin, serClk, frameSyncN};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stage[k] <= IDLE_VAL;
      prevLvl <= IDLE_VAL[1:0];
    end else begin
      stage[0] <= pins;
      for (int k = 1; k < STAGES; k++) stage[k] <= stage[k-1];
      prevLvl <= stage[STAGES-1][1:0];
    end
  end

  assign frameFall = prevLvl[0] & ~stage[STAGES-1][0];
  assign frameRise = ~prevLvl[0] & stage[STAGES-1][0];
  assign sclkFall  = prevLvl[1] & ~stage[STAGES-1][1];
  assign dinSmp    = stage[STAGES-1][2];

endmodule

// File: rtl/dacrx_ctrl.sv
module dacrx_ctrl
  import dacrx_pkg::*;
#(
  parameter int FRAME_W  = 24,
  parameter int PREFIX_W = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frameFall,
  input  logic          frameRise,
  input  logic          sclkFall,
  input  logic          rstCommit,
  output frameStrobes_t strobes
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] PFX_LEN  = CNT_W'(PREFIX_W);

  typedef enum logic [1:0] {ST_IDLE, ST_RECV, ST_DONE} ctrlState_e;

  ctrlState_e state, stateNxt;
  logic [CNT_W-1:0] bitCnt, bitCntNxt;

  always_comb begin
    strobes   = '0;
    stateNxt  = state;
    bitCntNxt = bitCnt;
    unique case (state)
      ST_IDLE: begin
        if (frameFall) begin
          strobes.clear = 1'b1;
          stateNxt      = ST_RECV;
          bitCntNxt     = '0;
        end
      end
      ST_RECV: begin
        if (frameRise) begin
          strobes.clear    = 1'b1;
          strobes.forceRst = (bitCnt >= PFX_LEN) && rstCommit;
          stateNxt         = ST_IDLE;
        end else if (sclkFall) begin
          strobes.shift  = 1'b1;
          strobes.prefix = (bitCnt < PFX_LEN);
          bitCntNxt      = bitCnt + 1'b1;
          if (bitCnt == LAST_IDX) begin
            strobes.exec = 1'b1;
            stateNxt     = ST_DONE;
          end
        end
      end
      ST_DONE: begin
        if (frameRise) stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      state  <= stateNxt;
      bitCnt <= bitCntNxt;
    end
  end

endmodule

// File: rtl/dacrx_datapath.sv
module dacrx_datapath
  import dacrx_pkg::*;
#(
  parameter int CODE_W    = 16,
  parameter bit RESET_MID = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  frameStrobes_t     strobes,
  input  logic              dinSmp,
  output logic              rstCommit,
  output logic [CODE_W-1:0] dacCode,
  output logic [1:0]        outMode,
  output logic              update
);
  localparam int SH_W = CODE_W + 1;  // keeps frame bits [CODE_W+1:1]
  localparam logic [CODE_W-1:0] RESET_CODE =
    RESET_MID ? {1'b1, {(CODE_W-1){1'b0}}} : '0;

  logic [SH_W-1:0]   shReg;
  logic              onesSoFar;
  logic [1:0]        cmdMode;
  logic [CODE_W-1:0] cmdCode;
  outStage_e         modeReg;

  assign cmdMode   = shReg[SH_W-1 -: 2];
  assign cmdCode   = {shReg[CODE_W-2:0], dinSmp};
  assign rstCommit = onesSoFar;

  always_ff @(posedge clk) begin
    if (rst) begin
      shReg     <= '0;
      onesSoFar <= 1'b1;
    end else if (strobes.clear) begin
      shReg     <= '0;
      onesSoFar <= 1'b1;
    end else if (strobes.shift) begin
      shReg <= {shReg[SH_W-2:0], dinSmp};
      if (strobes.prefix) onesSoFar <= onesSoFar & dinSmp;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dacCode <= RESET_CODE;
      modeReg <= MODE_DRIVE;
      update  <= 1'b0;
    end else begin
      update <= 1'b0;
      if (strobes.forceRst) begin
        dacCode <= RESET_CODE;
        modeReg <= MODE_DRIVE;
        update  <= 1'b1;
      end else if (strobes.exec) begin
        update <= 1'b1;
        if (onesSoFar) begin
          dacCode <= RESET_CODE;
          modeReg <= MODE_DRIVE;
        end else if (cmdMode == 2'b00) begin
          dacCode <= cmdCode;
          modeReg <= MODE_DRIVE;
        end else begin
          modeReg <= outStage_e'(cmdMode);
        end
      end
    end
  end

  assign outMode = modeReg;

endmodule

// File: rtl/dacrx_top.sv
module dacrx_top
  import dacrx_pkg::*;
#(
  parameter int CODE_W      = 16,
  parameter bit RESET_MID   = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frameSyncN,
  input  logic              serClk,
  input  logic              serDin,
  output logic [CODE_W-1:0] dacCode,
  output logic [1:0]        outMode,
  output logic              update
);
  localparam int FRAME_W  = (CODE_W == 16) ? 24 : CODE_W + 2;
  localparam int PREFIX_W = (CODE_W == 16) ? 1 : 2;

  logic frameFall, frameRise, sclkFall, dinSmp, rstCommit;
  frameStrobes_t strobes;

  dacrx_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .frameSyncN(frameSyncN), .serClk(serClk), .serDin(serDin),
    .frameFall(frameFall), .frameRise(frameRise),
    .sclkFall(sclkFall), .dinSmp(dinSmp)
  );

  dacrx_ctrl #(.FRAME_W(FRAME_W), .PREFIX_W(PREFIX_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .frameFall(frameFall), .frameRise(frameRise), .sclkFall(sclkFall),
    .rstCommit(rstCommit), .strobes(strobes)
  );

  dacrx_datapath #(.CODE_W(CODE_W), .RESET_MID(RESET_MID)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .dinSmp(dinSmp),
    .rstCommit(rstCommit), .dacCode(dacCode), .outMode(outMode),
    .update(update)
  );

endmodule

// File: rtl/dacrx_checker.sv
module dacrx_checker #(
  parameter int CODE_W    = 16,
  parameter bit RESET_MID = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic [CODE_W-1:0] dacCode,
  input logic [1:0]        outMode,
  input logic              update
);
  localparam logic [CODE_W-1:0] START_CODE =
    RESET_MID ? {1'b1, {(CODE_W-1){1'b0}}} : '0;

  // R1: first cycle out of reset shows the power-up state
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dacCode == START_CODE && outMode == 2'b00 && !update));

  // R2: the strobe never lasts two cycles
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    update |=> !update);

  // R3: the code moves only together with the strobe
  p_code_with_update_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(dacCode) |-> update);

  // R4: the mode moves only together with the strobe
  p_mode_with_update_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(outMode) |-> update);

  // R5: a power-down command leaves the stored code alone
  p_pd_keeps_code_r5: assert property (@(posedge clk) disable iff (rst)
    (update && outMode != 2'b00) |-> $stable(dacCode));

endmodule

bind dacrx_top dacrx_checker #(.CODE_W(CODE_W), .RESET_MID(RESET_MID)) u_chk (
  .clk(clk), .rst(rst), .dacCode(dacCode), .outMode(outMode), .update(update)
);

// File: tb/dacrx_top_tb.sv
module dacrx_top_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frameSyncN = 1'b1;
  logic serClk = 1'b0;
  logic serDin = 1'b0;
  logic [15:0] dacCode;
  logic [1:0]  outMode;
  logic        update;

  always #2.5 clk = ~clk;  // 200 MHz

  dacrx_top u_dut (
    .clk(clk), .rst(rst), .frameSyncN(frameSyncN), .serClk(serClk),
    .serDin(serDin), .dacCode(dacCode), .outMode(outMode), .update(update)
  );

  typedef struct {
    logic [15:0] code;
    logic [1:0]  mode;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int fails  = 0;
  logic [15:0] mCode = 16'h8000;
  logic [1:0]  mMode = 2'b00;
  bit finished = 1'b0;

  task automatic checkEq(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pushExp(string tag);
    expItem_t it;
    it.code = mCode; it.mode = mMode; it.tag = tag;
    expQ.push_back(it);
  endtask

  // drive nbits of w (MSB first), then extra clock edges, then optional sync rise
  task automatic drive(logic [23:0] w, int nbits, int extra, bit raise);
    frameSyncN = 1'b0;
    waitN(4);
    for (int i = 0; i < nbits; i++) begin
      serDin = w[23-i];
      serClk = 1'b1; waitN(4);
      serClk = 1'b0; waitN(4);
    end
    for (int i = 0; i < extra; i++) begin
      serDin = 1'b1;
      serClk = 1'b1; waitN(4);
      serClk = 1'b0; waitN(4);
    end
    waitN(2);
    if (raise) frameSyncN = 1'b1;
    waitN(8);
  endtask

  task automatic predictFull(logic [23:0] w);
    if (w[23]) begin mCode = 16'h8000; mMode = 2'b00; end
    else if (w[17:16] == 2'b00) begin mCode = w[15:0]; mMode = 2'b00; end
    else mMode = w[17:16];
  endtask

  task automatic checkPorts(string tag);
    checkEq({tag, " code"}, 32'(dacCode), 32'(mCode));
    checkEq({tag, " mode"}, 32'(outMode), 32'(mMode));
    checkEq({tag, " strobe idle"}, 32'(update), 32'd0);
  endtask

  task automatic fullFrame(logic [23:0] w, string tag, int extra = 0);
    predictFull(w);
    pushExp(tag);
    drive(w, 24, extra, 1'b1);
    checkPorts(tag);
  endtask

  task automatic cutFrame(logic [23:0] w, int nbits, string tag);
    if (nbits >= 1 && w[23]) begin
      mCode = 16'h8000; mMode = 2'b00;
      pushExp(tag);
    end
    drive(w, nbits, 0, 1'b1);
    checkPorts(tag);
  endtask

  // monitor: scoreboard side
  always @(negedge clk) begin
    if (!rst && update) begin
      checks++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL R2 unexpected update actual code=%h mode=%b expected no strobe",
                 dacCode, outMode);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        if (dacCode !== it.code || outMode !== it.mode) begin
          fails++;
          $display("FAIL %s at strobe actual=%h/%b expected=%h/%b",
                   it.tag, dacCode, outMode, it.code, it.mode);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    waitN(10);
    rst = 1'b0;
    waitN(2);
    // R1 reset state
    checkPorts("R1");

    // R3 normal loads, several patterns
    fullFrame(24'h00_1234, "R3");
    fullFrame(24'h00_FFFF, "R3");
    fullFrame(24'h00_0000, "R3");
    fullFrame(24'h00_A5C3, "R3");

    // R4 / R5 power-down modes keep the code
    fullFrame(24'h01_BEEF, "R4");
    fullFrame(24'h02_0000, "R5");
    fullFrame(24'h03_1111, "R4");
    fullFrame(24'h00_4321, "R5");

    // R6 aborts of ordinary frames
    cutFrame(24'h00_7777, 10, "R6");
    cutFrame(24'h00_7777, 23, "R6");
    cutFrame(24'h02_7777, 0, "R6");
    fullFrame(24'h00_0F0F, "R6");

    // R7 software reset by a full frame
    fullFrame(24'h00_1357, "R7");
    fullFrame(24'h02_0000, "R7");
    fullFrame(24'hFF_FFFF, "R7");

    // R8 software reset cut short still executes
    fullFrame(24'h03_2468, "R8");
    fullFrame(24'h00_2468, "R8");
    cutFrame(24'hFF_FFFF, 5, "R8");
    fullFrame(24'h00_1111, "R8");
    cutFrame(24'h80_0000, 1, "R8");

    // R9 surplus clock edges after the word
    fullFrame(24'h00_3C3C, "R9", 6);
    fullFrame(24'h01_0000, "R9", 3);

    // R10 clock edges with the frame select high
    for (int i = 0; i < 30; i++) begin
      serDin = 1'b1;
      serClk = 1'b1; waitN(4);
      serClk = 1'b0; waitN(4);
    end
    waitN(6);
    checkPorts("R10");
    fullFrame(24'h00_5A5A, "R10");

    // R2 every predicted strobe was seen
    waitN(10);
    checkEq("R2 pending strobes", 32'(expQ.size()), 32'd0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule